// File: doc/BRIEF.md
# Proximity Measurement Sequencer

This block decides when a proximity measurement happens, drives the emitter for it, and turns the converter's raw count into the proximity result word. In free-running mode it starts one measurement per period, and a 2-bit duty code sets the period. In forced mode it waits in standby. A write strobe on the trigger bit then starts exactly one measurement, and the trigger bit clears itself.

Each measurement has four steps:
1. The emitter enable is held high for a length set by a 3-bit integration code. The length is counted in half-T units, and T is a parameter in clock cycles.
2. A one-cycle conversion-start strobe goes to the external converter.
3. The sequencer waits for the converter's valid strobe.
4. It subtracts a programmable crosstalk cancellation value from the raw count. It then limits the difference to a 12-bit or a 16-bit result and registers it. A one-cycle sample-valid strobe marks the new result.

Shutdown is the reset state. While shutdown is set, nothing is measured.

Top module: `prox_seq`

## Requirements
- R1: After reset, `emit_en`, `conv_start`, `result_valid` and `result` are all 0. While `shutdown` is 1, no emitter pulse, conversion start or result occurs. A trigger write made during shutdown is discarded.
- R2: With `force_mode`=0 and `shutdown`=0, emitter pulses begin every DUTY_BASE*T_CYC*2^`duty` cycles. `duty` codes 0,1,2,3 correspond to on/off ratios 1/40, 1/80, 1/160 and 1/320, which is 160, 320, 640 and 1280 cycles at the default parameters. The first pulse begins at once when the block leaves shutdown.
- R3: With `force_mode`=1, each accepted one-cycle `trig_wr` pulse starts exactly one measurement. The emitter enable rises on the clock edge after the edge that samples the write. No other measurement is made.
- R4: A `trig_wr` that arrives while a measurement is in progress (emitter on, conversion pending) is discarded. The trigger bit always returns to 0, so a single write never yields a second measurement.
- R5: The emitter enable stays high for H*(T_CYC/2) consecutive cycles. H is the half-T count for `it_code`: codes 0..7 give H = 2,3,4,5,6,7,8,16 (1T, 1.5T, 2T, 2.5T, 3T, 3.5T, 4T, 8T).
- R6: `conv_start` is high for exactly one cycle, the cycle right after the last emitter cycle, and it is never high together with `emit_en`.
- R7: The result is `raw_count` minus `cancel`. When the cancellation value exceeds the raw count, the result saturates at 0.
- R8: When `res_hi`=1, the result carries the full 16 bits. When `res_hi`=0, any difference above 4095 becomes 4095, so the upper four result bits are 0.
- R9: The result changes only on a capture. `result_valid` goes high for one cycle, on the first cycle that shows the new result. That cycle is one clock after the cycle in which `raw_valid` is high, provided a conversion is pending.
- R10: Setting `shutdown` during a measurement cancels it. The emitter enable falls on the next edge, and that measurement produces no conversion start and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shutdown | input | 1 | Stops all measurements when 1 |
| force_mode | input | 1 | 1 selects single-shot forced mode, 0 selects free-running mode |
| duty | input | 2 | Period code for free-running mode |
| it_code | input | 3 | Integration-time code (emitter length) |
| res_hi | input | 1 | 1 gives a 16-bit result, 0 gives a 12-bit saturated result |
| cancel | input | 16 | Crosstalk cancellation value |
| trig_wr | input | 1 | One-cycle write of 1 to the trigger bit |
| raw_valid | input | 1 | Converter count valid |
| raw_count | input | 16 | Converter raw count |
| emit_en | output | 1 | Emitter enable |
| conv_start | output | 1 | One-cycle conversion start |
| result | output | 16 | Proximity result register |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Each result has a fixed delay from its stimulus:
- The emitter enable is first seen high two cycles after a trigger write is driven.
- It then stays high for the cycle count that R5 gives.
- `conv_start` is seen high at the first sample after the emitter falls.
- `result_valid` is seen exactly one sample after `raw_valid`.

The bench counts falling-edge samples from each stimulus and checks every output at exactly these offsets. Free-running periods are measured as the sample count between two consecutive emitter rises. Checks that something was ignored count conversion starts and valid strobes over a window well longer than one measurement.

// File: rtl/prox_pkg.sv
package prox_pkg;

   localparam int IT_CODES   = 8;
   localparam int DUTY_CODES = 4;
   localparam int HALF_MAX   = 16;

   // Emitter length in half-T units for one integration code.
   function automatic int unsigned half_units(input logic [2:0] code);
      if (code == 3'd7) return 16;
      return int'(code) + 2;
   endfunction

   // Period multiplier for one duty code.
   function automatic int unsigned duty_mult(input logic [1:0] code);
      return 1 << code;
   endfunction

endpackage

// File: rtl/prox_pulse.sv
module prox_pulse #(
   parameter int T_CYC = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic [2:0] it_code,
   input  logic       abort,
   output logic       active,
   output logic       done
);
   localparam int HALF    = T_CYC / 2;
   localparam int MAX_LEN = prox_pkg::HALF_MAX * HALF;
   localparam int LEN_W   = $clog2(MAX_LEN + 1);

   logic [LEN_W-1:0] len_tab [prox_pkg::IT_CODES];
   logic [LEN_W-1:0] cnt;

   for (genvar g = 0; g < prox_pkg::IT_CODES; g++) begin : g_len
      assign len_tab[g] = LEN_W'(prox_pkg::half_units(3'(g)) * HALF);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         active <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (active) begin
            if (abort) begin
               active <= 1'b0;
            end else if (cnt == '0) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (load) begin
            active <= 1'b1;
            cnt    <= len_tab[it_code] - 1'b1;
         end
      end
   end

endmodule

// File: rtl/prox_sched.sv
module prox_sched #(
   parameter int T_CYC     = 4,
   parameter int DUTY_BASE = 40
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       shutdown,
   input  logic       force_mode,
   input  logic [1:0] duty,
   input  logic       trig_wr,
   input  logic       emit_active,
   input  logic       conv_start,
   input  logic       raw_valid,
   output logic       start,
   output logic       capture
);
   localparam int PER_UNIT = DUTY_BASE * T_CYC;
   localparam int PER_MAX  = PER_UNIT * (1 << (prox_pkg::DUTY_CODES - 1));
   localparam int PER_W    = $clog2(PER_MAX + 1);

   logic [PER_W-1:0] per_tab [prox_pkg::DUTY_CODES];
   logic [PER_W-1:0] per_cnt;
   logic             trig_q;
   logic             wait_raw;
   logic             idle;
   logic             due;

   for (genvar g = 0; g < prox_pkg::DUTY_CODES; g++) begin : g_per
      assign per_tab[g] = PER_W'(PER_UNIT * prox_pkg::duty_mult(2'(g)));
   end

   assign idle    = !emit_active && !conv_start && !wait_raw;
   assign due     = force_mode ? trig_q : (per_cnt == '0);
   assign start   = idle && !shutdown && due;
   assign capture = (conv_start || wait_raw) && raw_valid && !shutdown;

   // Self-clearing trigger bit: only set when idle, cleared when used.
   always_ff @(posedge clk) begin
      if (rst || shutdown || !force_mode) begin
         trig_q <= 1'b0;
      end else if (start) begin
         trig_q <= 1'b0;
      end else if (trig_wr && idle && !trig_q) begin
         trig_q <= 1'b1;
      end
   end

   // Free-running period counter.
   always_ff @(posedge clk) begin
      if (rst || shutdown || force_mode) begin
         per_cnt <= '0;
      end else if (start) begin
         per_cnt <= per_tab[duty] - 1'b1;
      end else if (per_cnt != '0) begin
         per_cnt <= per_cnt - 1'b1;
      end
   end

   // Conversion pending until the converter answers.
   always_ff @(posedge clk) begin
      if (rst || shutdown) begin
         wait_raw <= 1'b0;
      end else begin
         wait_raw <= (conv_start || wait_raw) && !raw_valid;
      end
   end

endmodule

// File: rtl/prox_post.sv
module prox_post #(
   parameter int RAW_W = 16,
   parameter int LO_W  = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic [RAW_W-1:0] raw,
   input  logic [RAW_W-1:0] canc,
   input  logic             res_hi,
   output logic [RAW_W-1:0] result,
   output logic             valid
);
   logic [RAW_W:0]   diff;
   logic [RAW_W-1:0] mag;
   logic [RAW_W-1:0] lo_val;
   logic [RAW_W-1:0] next_val;

   assign diff = {1'b0, raw} - {1'b0, canc};
   assign mag  = diff[RAW_W] ? '0 : diff[RAW_W-1:0];

   if (LO_W < RAW_W) begin : g_clamp
      localparam logic [RAW_W-1:0] LO_MAX = RAW_W'((1 << LO_W) - 1);
      assign lo_val = (|mag[RAW_W-1:LO_W]) ? LO_MAX : mag;
   end else begin : g_pass
      assign lo_val = mag;
   end

   assign next_val = res_hi ? mag : lo_val;

   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         valid  <= 1'b0;
      end else begin
         valid <= capture;
         if (capture) result <= next_val;
      end
   end

endmodule

// File: rtl/prox_seq.sv
module prox_seq #(
   parameter int T_CYC     = 4,
   parameter int DUTY_BASE = 40,
   parameter int RAW_W     = 16,
   parameter int LO_W      = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shutdown,
   input  logic             force_mode,
   input  logic [1:0]       duty,
   input  logic [2:0]       it_code,
   input  logic             res_hi,
   input  logic [RAW_W-1:0] cancel,
   input  logic             trig_wr,
   input  logic             raw_valid,
   input  logic [RAW_W-1:0] raw_count,
   output logic             emit_en,
   output logic             conv_start,
   output logic [RAW_W-1:0] result,
   output logic             result_valid
);
   if (T_CYC < 2 || (T_CYC % 2) != 0) begin : g_bad_t
      $error("T_CYC must be even and at least 2");
   end
   if (DUTY_BASE <= prox_pkg::HALF_MAX) begin : g_bad_duty
      $error("DUTY_BASE too small for the longest emitter pulse");
   end
   if (LO_W < 1 || LO_W > RAW_W) begin : g_bad_w
      $error("LO_W must lie in 1..RAW_W");
   end

   logic start;
   logic capture;

   prox_sched #(.T_CYC(T_CYC), .DUTY_BASE(DUTY_BASE)) u_sched (
      .clk        (clk),
      .rst        (rst),
      .shutdown   (shutdown),
      .force_mode (force_mode),
      .duty       (duty),
      .trig_wr    (trig_wr),
      .emit_active(emit_en),
      .conv_start (conv_start),
      .raw_valid  (raw_valid),
      .start      (start),
      .capture    (capture)
   );

   prox_pulse #(.T_CYC(T_CYC)) u_pulse (
      .clk    (clk),
      .rst    (rst),
      .load   (start),
      .it_code(it_code),
      .abort  (shutdown),
      .active (emit_en),
      .done   (conv_start)
   );

   prox_post #(.RAW_W(RAW_W), .LO_W(LO_W)) u_post (
      .clk    (clk),
      .rst    (rst),
      .capture(capture),
      .raw    (raw_count),
      .canc   (cancel),
      .res_hi (res_hi),
      .result (result),
      .valid  (result_valid)
   );

endmodule

// File: rtl/prox_seq_chk.sv
module prox_seq_chk #(
   parameter int RAW_W = 16,
   parameter int LO_W  = 12
) (
   input logic             clk,
   input logic             rst,
   input logic             shutdown,
   input logic             res_hi,
   input logic             emit_en,
   input logic             conv_start,
   input logic [RAW_W-1:0] result,
   input logic             result_valid
);
   AST_SD_QUIET: assert property (@(posedge clk) disable iff (rst)
      shutdown |=> (!emit_en && !conv_start)); // R10

   AST_CONV_AFTER_EMIT: assert property (@(posedge clk) disable iff (rst)
      conv_start |-> $past(emit_en)); // R6

   AST_EMIT_THEN_CONV: assert property (@(posedge clk) disable iff (rst)
      ($fell(emit_en) && !$past(shutdown)) |-> conv_start); // R6

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      !(emit_en && conv_start)); // R6

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      result_valid |=> !result_valid); // R9

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !result_valid |-> $stable(result)); // R9

   AST_NARROW_MAX: assert property (@(posedge clk) disable iff (rst)
      (result_valid && !$past(res_hi)) |-> (result < RAW_W'(1 << LO_W))); // R8

endmodule

bind prox_seq prox_seq_chk #(.RAW_W(RAW_W), .LO_W(LO_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .shutdown    (shutdown),
   .res_hi      (res_hi),
   .emit_en     (emit_en),
   .conv_start  (conv_start),
   .result      (result),
   .result_valid(result_valid)
);

// File: tb/prox_seq_test.sv
`timescale 1ns/1ps
module prox_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        shutdown = 1'b1;
   logic        force_mode = 1'b0;
   logic [1:0]  duty = 2'd0;
   logic [2:0]  it_code = 3'd0;
   logic        res_hi = 1'b1;
   logic [15:0] cancel = 16'd0;
   logic        trig_wr = 1'b0;
   logic        raw_valid = 1'b0;
   logic [15:0] raw_count = 16'd0;
   logic        emit_en;
   logic        conv_start;
   logic [15:0] result;
   logic        result_valid;

   int n_tests = 0;
   int n_fail  = 0;
   int n_conv  = 0;
   int n_valid = 0;
   int lat     = 0;
   logic [15:0] cur_raw = 16'd0;

   always #2 clk = ~clk;

   prox_seq uut (
      .clk(clk), .rst(rst), .shutdown(shutdown), .force_mode(force_mode),
      .duty(duty), .it_code(it_code), .res_hi(res_hi), .cancel(cancel),
      .trig_wr(trig_wr), .raw_valid(raw_valid), .raw_count(raw_count),
      .emit_en(emit_en), .conv_start(conv_start), .result(result),
      .result_valid(result_valid)
   );

   // Converter model: answers three cycles after a conversion start.
   always @(posedge clk) begin
      if (conv_start) lat <= 3;
      else if (lat != 0) lat <= lat - 1;
      raw_valid <= (lat == 1);
      raw_count <= cur_raw;
      if (!rst && conv_start) n_conv = n_conv + 1;
      if (!rst && result_valid) n_valid = n_valid + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int emit_len(input int code);
      return (code == 7) ? 32 : (code + 2) * 2;
   endfunction

   // it(3) canc(16) raw(16) res_hi(1) expected(16)
   localparam int NV = 8;
   localparam logic [51:0] VEC [NV] = '{
      {3'd0, 16'h0000, 16'h0123, 1'b1, 16'h0123},
      {3'd1, 16'h0010, 16'h0100, 1'b0, 16'h00F0},
      {3'd2, 16'h0200, 16'h0100, 1'b1, 16'h0000},
      {3'd3, 16'h0000, 16'hFFFF, 1'b1, 16'hFFFF},
      {3'd4, 16'h0000, 16'h2000, 1'b0, 16'h0FFF},
      {3'd5, 16'h1000, 16'h1FFF, 1'b0, 16'h0FFF},
      {3'd6, 16'h0ABC, 16'h0ABC, 1'b0, 16'h0000},
      {3'd7, 16'h0001, 16'h1001, 1'b0, 16'h0FFF}
   };

   task automatic pulse_trig();
      trig_wr = 1'b1;
      @(negedge clk);
      trig_wr = 1'b0;
   endtask

   // One forced measurement with full timing checks.
   task automatic forced_run(input int code, input logic [15:0] canc,
                             input logic [15:0] raw, input logic hi,
                             input logic [15:0] exp);
      int cnt;
      int len;
      int t_raw;
      int t_val;
      int wait_cnt;
      it_code = 3'(code);
      cancel  = canc;
      cur_raw = raw;
      res_hi  = hi;
      trig_wr = 1'b1;
      cnt = 0;
      @(negedge clk);
      trig_wr = 1'b0;
      cnt = 1;
      while (!emit_en && cnt < 20) begin
         @(negedge clk);
         cnt++;
      end
      check("R3 trigger to emitter cycles", cnt, 2);
      len = 0;
      while (emit_en && len < 100) begin
         len++;
         @(negedge clk);
      end
      check("R5 emitter length", len, emit_len(code));
      check("R6 conv_start after emitter", int'(conv_start), 1);
      @(negedge clk);
      check("R6 conv_start single cycle", int'(conv_start), 0);
      t_raw = -1;
      t_val = -1;
      wait_cnt = 0;
      while (t_val < 0 && wait_cnt < 50) begin
         if (raw_valid) t_raw = wait_cnt;
         if (result_valid) t_val = wait_cnt;
         @(negedge clk);
         wait_cnt++;
      end
      check("R9 valid one cycle after raw", t_val - t_raw, 1);
      check("R7 R8 result value", int'(result), int'(exp));
      check("R9 valid single cycle", int'(result_valid), 0);
   endtask

   task automatic period_run(input logic [1:0] d, input int exp);
      int guard;
      int per;
      duty = d;
      force_mode = 1'b0;
      it_code = 3'd0;
      shutdown = 1'b0;
      guard = 0;
      while (!emit_en && guard < 10) begin @(negedge clk); guard++; end
      check("R2 first pulse at leaving shutdown", int'(guard <= 2), 1);
      while (emit_en) @(negedge clk);
      per = emit_len(0);
      while (!emit_en && per < 5000) begin @(negedge clk); per++; end
      check("R2 free-running period", per, exp);
      shutdown = 1'b1;
      repeat (20) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      int c0;
      int v0;
      int seen;
      repeat (3) @(negedge clk);
      check("R1 reset emit_en", int'(emit_en), 0);
      check("R1 reset conv_start", int'(conv_start), 0);
      check("R1 reset result_valid", int'(result_valid), 0);
      check("R1 reset result", int'(result), 0);
      rst = 1'b0;

      // R1: shutdown blocks free-running and forced measurements
      seen = 0;
      repeat (400) begin @(negedge clk); if (emit_en) seen++; end
      force_mode = 1'b1;
      pulse_trig();
      repeat (100) begin @(negedge clk); if (emit_en) seen++; end
      check("R1 no emitter in shutdown", seen, 0);
      check("R1 no conversion in shutdown", n_conv, 0);

      // Vector table walk in forced mode (R3 R5 R6 R7 R8 R9)
      shutdown = 1'b0;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         forced_run(int'(VEC[i][51:49]), VEC[i][48:33], VEC[i][32:17],
                    VEC[i][16], VEC[i][15:0]);
         repeat (5) @(negedge clk);
      end
      check("R3 one conversion per trigger", n_conv, NV);
      check("R3 one result per trigger", n_valid, NV);

      // R4: trigger during a busy measurement is discarded
      c0 = n_conv;
      v0 = n_valid;
      it_code = 3'd7;
      pulse_trig();
      @(negedge clk);
      check("R4 emitter running", int'(emit_en), 1);
      pulse_trig();
      repeat (300) @(negedge clk);
      check("R4 busy trigger ignored conv", n_conv - c0, 1);
      check("R4 busy trigger ignored valid", n_valid - v0, 1);

      // R2: free-running periods
      shutdown = 1'b1;
      @(negedge clk);
      period_run(2'd0, 160);
      period_run(2'd1, 320);
      period_run(2'd3, 1280);

      // R10: shutdown aborts a measurement
      it_code = 3'd7;
      force_mode = 1'b0;
      shutdown = 1'b0;
      while (!emit_en) @(negedge clk);
      repeat (4) @(negedge clk);
      c0 = n_conv;
      v0 = n_valid;
      shutdown = 1'b1;
      @(negedge clk);
      check("R10 emitter off after shutdown", int'(emit_en), 0);
      repeat (60) @(negedge clk);
      check("R10 no conversion after abort", n_conv - c0, 0);
      check("R10 no result after abort", n_valid - v0, 0);
      check("R10 result held", int'(result), 16'h0FFF);

      finish_up();
   end
endmodule